// File: doc/BRIEF.md
# Buffered Repeat Down-Counter Timer

The block is a down-counting timer driven by a timer-clock enable. While running it decrements a count register once per enabled clock. When the count is already zero on an enabled clock it underflows: it reloads from the active period register, pulses an underflow output and sets a sticky flag. A repeat counter is charged on each underflow. When that counter runs out, a second period/repeat pair is handed over to the active pair if that pair has not yet been used. The timer then keeps running with the new period. If the second pair has already been used, the timer halts with the count and the repeat counter at zero.

Software-side control is a simple select/data write port plus start and stop strobes. Starting the timer loads nothing, so the first run length is whatever the count register holds. This lets a caller preload an odd first interval. Two interrupt sources, underflow and repeat exhaustion, share one interrupt line through an enable mask.

Top module: `rpt_timer`

## Requirements
- R1: While running, the count decrements by one on each clock where `tick` is high and holds on clocks where `tick` is low; while stopped it never changes except by a write.
- R2: Start (`start` high for a clock) writes no register, so the first underflow occurs on the (CNT+1)-th enabled clock after start.
- R3: On an enabled clock with the count at zero while running, `uf_o` pulses in that clock, flag bit 0 is set, and the repeat counter drops by one unless it is exhausted. The count reloads from the active period, except in the cases R4 and R6 describe.
- R4: The repeat counter is exhausted when it holds 1 or 0 at an underflow. If the buffered pair is unused, the buffered repeat value and period are copied into the active pair, the count loads the buffered period, the buffer is marked used and running continues.
- R5: Every exhaustion pulses `rep_done_o` together with `uf_o` and sets flag bit 1.
- R6: An exhaustion with the buffer already marked used stops the timer, leaving the count and the repeat counter both at 0.
- R7: A write to the buffered repeat value clears the used mark; nothing else clears it.
- R8: Flags are sticky. A write with select 6 clears each flag whose data bit is 1, and a flag set in the same clock wins over the clear.
- R9: `irq_o` is high exactly when some flag bit and its enable bit are both 1; enables are written with select 5.
- R10: `stop` freezes the count and the repeat counter at their current values. When `start` and `stop` come together, stop wins.
- R11: Write selects are: 0 count, 1 active period, 2 buffered period, 3 active repeat, 4 buffered repeat, 5 interrupt enables, 6 flag clear. A write takes effect at the clock edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable |
| start | input | 1 | Start strobe |
| stop | input | 1 | Stop strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (R11) |
| wr_data | input | CNT_W | Write data |
| running_o | output | 1 | Timer running |
| cnt_o | output | CNT_W | Current count |
| rep0_o | output | REP_W | Active repeat counter |
| uf_o | output | 1 | Underflow pulse |
| rep_done_o | output | 1 | Repeat exhaustion pulse |
| flags_o | output | 2 | Sticky flags: bit 0 underflow, bit 1 exhaustion |
| irq_o | output | 1 | Combined interrupt |

## Verification
The checks that relate one cycle to the next assume that no register write lands in the same clock they are looking at. The bench honours this by writing only while the timer is stopped or in clocks where no counting edge is checked. The halt check also assumes no start coincides with an exhaustion, and the bench only issues start while the timer is stopped. The `tick` input is free-running or toggling, which covers both the counting and the holding behaviour.

// File: rtl/rpt_timer_pkg.sv
package rpt_timer_pkg;
  typedef enum logic [2:0] {
    SEL_CNT  = 3'd0,
    SEL_PER0 = 3'd1,
    SEL_PER1 = 3'd2,
    SEL_RPT0 = 3'd3,
    SEL_RPT1 = 3'd4,
    SEL_IEN  = 3'd5,
    SEL_ICLR = 3'd6
  } reg_sel_e;

  localparam int NFLAG   = 2;
  localparam int FLAG_UF = 0;
  localparam int FLAG_RD = 1;
endpackage

// File: rtl/rpt_count_core.sv
module rpt_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          running,
  input  logic          wr_cnt,
  input  logic          wr_per0,
  input  logic          wr_per1,
  input  logic [CW-1:0] wr_data,
  input  logic          load_buf,
  input  logic          halt,
  output logic [CW-1:0] cnt,
  output logic          uf
);
  logic [CW-1:0] per0, per1;
  logic [CW-1:0] cnt_nx, per0_nx, per1_nx;

  assign uf = running && tick && (cnt == '0);

  always_comb begin
    cnt_nx  = cnt;
    per0_nx = per0;
    per1_nx = per1;
    if (uf) begin
      if (halt)          cnt_nx = '0;
      else if (load_buf) cnt_nx = per1;
      else               cnt_nx = per0;
    end else if (running && tick) begin
      cnt_nx = cnt - CW'(1);
    end
    if (load_buf) per0_nx = per1;
    if (wr_cnt)   cnt_nx  = wr_data;
    if (wr_per0)  per0_nx = wr_data;
    if (wr_per1)  per1_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      per0 <= '0;
      per1 <= '0;
    end else begin
      cnt  <= cnt_nx;
      per0 <= per0_nx;
      per1 <= per1_nx;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && cnt != '0 && !wr_cnt) |=> (cnt == $past(cnt) - CW'(1)));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !load_buf && !halt && !wr_cnt) |=> (cnt == $past(per0)));
endmodule

// File: rtl/rpt_repeat_unit.sv
module rpt_repeat_unit #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          uf,
  input  logic          wr_rpt0,
  input  logic          wr_rpt1,
  input  logic [RW-1:0] wr_data,
  output logic [RW-1:0] rpt0,
  output logic          rep_done,
  output logic          load_buf,
  output logic          halt
);
  logic [RW-1:0] rpt1, rpt0_nx, rpt1_nx;
  logic          used, used_nx;

  assign rep_done = uf && (rpt0 <= RW'(1));
  assign load_buf = rep_done && !used;
  assign halt     = rep_done && used;

  always_comb begin
    rpt0_nx = rpt0;
    rpt1_nx = rpt1;
    used_nx = used;
    if (uf) begin
      if (halt)          rpt0_nx = '0;
      else if (load_buf) rpt0_nx = rpt1;
      else               rpt0_nx = rpt0 - RW'(1);
    end
    if (load_buf) used_nx = 1'b1;
    if (wr_rpt0) rpt0_nx = wr_data;
    if (wr_rpt1) begin
      rpt1_nx = wr_data;
      used_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt0 <= '0;
      rpt1 <= '0;
      used <= 1'b0;
    end else begin
      rpt0 <= rpt0_nx;
      rpt1 <= rpt1_nx;
      used <= used_nx;
    end
  end

  assert_rep_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !rep_done && !wr_rpt0) |=> (rpt0 == $past(rpt0) - RW'(1)));

  assert_buf_handover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_buf && !wr_rpt0 && !wr_rpt1) |=> (used && rpt0 == $past(rpt1)));

  assert_used_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(used) |-> $past(wr_rpt1));
endmodule

// File: rtl/rpt_irq_unit.sv
module rpt_irq_unit
  import rpt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             wr_ien,
  input  logic             wr_clr,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] ien, flags_nx, ien_nx, clr_mask;

  assign clr_mask = wr_clr ? wr_data : '0;

  always_comb begin
    flags_nx = (flags & ~clr_mask) | set_vec;
    ien_nx   = wr_ien ? wr_data : ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ien   <= '0;
    end else begin
      flags <= flags_nx;
      ien   <= ien_nx;
    end
  end

  assign irq = |(flags & ien);

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((flags & $past(flags)) == $past(flags)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/rpt_timer.sv
module rpt_timer
  import rpt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             running_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [REP_W-1:0] rep0_o,
  output logic             uf_o,
  output logic             rep_done_o,
  output logic [1:0]       flags_o,
  output logic             irq_o
);
  localparam int SEL_W = $bits(reg_sel_e);

  logic running, running_nx;
  logic uf, rep_done, load_buf, halt;
  logic wr_cnt, wr_per0, wr_per1, wr_rpt0, wr_rpt1, wr_ien, wr_clr;
  logic [NFLAG-1:0] set_vec;

  assign wr_cnt  = wr_en && (wr_sel == SEL_W'(SEL_CNT));
  assign wr_per0 = wr_en && (wr_sel == SEL_W'(SEL_PER0));
  assign wr_per1 = wr_en && (wr_sel == SEL_W'(SEL_PER1));
  assign wr_rpt0 = wr_en && (wr_sel == SEL_W'(SEL_RPT0));
  assign wr_rpt1 = wr_en && (wr_sel == SEL_W'(SEL_RPT1));
  assign wr_ien  = wr_en && (wr_sel == SEL_W'(SEL_IEN));
  assign wr_clr  = wr_en && (wr_sel == SEL_W'(SEL_ICLR));

  always_comb begin
    running_nx = running;
    if (start) running_nx = 1'b1;
    if (halt)  running_nx = 1'b0;
    if (stop)  running_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= running_nx;
  end

  rpt_count_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
    .wr_cnt(wr_cnt), .wr_per0(wr_per0), .wr_per1(wr_per1), .wr_data(wr_data),
    .load_buf(load_buf), .halt(halt), .cnt(cnt_o), .uf(uf)
  );

  rpt_repeat_unit #(.RW(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .uf(uf), .wr_rpt0(wr_rpt0), .wr_rpt1(wr_rpt1),
    .wr_data(wr_data[REP_W-1:0]), .rpt0(rep0_o), .rep_done(rep_done),
    .load_buf(load_buf), .halt(halt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLAG_UF] = uf;
    set_vec[FLAG_RD] = rep_done;
  end

  rpt_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_ien(wr_ien),
    .wr_clr(wr_clr), .wr_data(wr_data[NFLAG-1:0]), .flags(flags_o), .irq(irq_o)
  );

  assign running_o  = running;
  assign uf_o       = uf;
  assign rep_done_o = rep_done;

  assert_halt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start && !wr_en) |=> (!running && cnt_o == '0 && rep0_o == '0));

  assert_stop_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !wr_en) |=> ($stable(cnt_o) && $stable(rep0_o)));

  assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);

  assert_done_with_uf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_done_o |-> uf_o);
endmodule

// File: tb/test_rpt_timer.sv
`timescale 1ns/1ps
module test_rpt_timer;
  localparam int CW = 16;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n, tick, start, stop, wr_en;
  logic [2:0] wr_sel;
  logic [CW-1:0] wr_data;
  logic running_o, uf_o, rep_done_o, irq_o;
  logic [CW-1:0] cnt_o;
  logic [RW-1:0] rep0_o;
  logic [1:0] flags_o;

  int n_chk = 0, n_fail = 0;
  int mon_tk = 0;
  int q_tk[$];
  bit q_rd[$];
  bit buf_used = 0;
  bit tick_toggle = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rpt_timer #(.CNT_W(CW), .REP_W(RW)) i_rpt_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .running_o(running_o), .cnt_o(cnt_o), .rep0_o(rep0_o), .uf_o(uf_o),
    .rep_done_o(rep_done_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (tick_toggle) tick = ~tick;
    else tick = 1'b1;
  end

  // monitor: pops expected underflow events and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (running_o && tick) mon_tk++;
      if (uf_o) begin
        if (q_tk.size() == 0) chk(0, "R3 unexpected underflow", mon_tk, -1);
        else begin
          int et; bit er;
          et = q_tk.pop_front();
          er = q_rd.pop_front();
          chk(mon_tk == et, "R2/R3 underflow tick", mon_tk, et);
          chk(rep_done_o == er, "R4/R5 repeat-done pulse", rep_done_o, er);
        end
      end else if (rep_done_o) chk(0, "R5 done without underflow", 1, 0);
    end
  end

  task automatic wr(input logic [2:0] s, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = CW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (s == 3'd4) buf_used = 0;
  endtask

  // driver: push expected events derived from the requirements
  task automatic expect_run(input int c, input int t0, input int r0, input int t1, input int r1);
    int tk = c + 1;
    int rep = r0;
    for (int i = 0; i < 64; i++) begin
      q_tk.push_back(tk);
      q_rd.push_back(rep <= 1);
      if (rep <= 1) begin
        if (buf_used) break;
        rep = r1; t0 = t1; buf_used = 1;
        tk += t1 + 1;
      end else begin
        rep--;
        tk += t0 + 1;
      end
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1;
    start = 1'b1; mon_tk = 0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!running_o) break;
    end
    @(negedge clk);
    chk(!running_o, "R6 timer halted", running_o, 0);
    chk(q_tk.size() == 0, "R3 all underflows seen", q_tk.size(), 0);
    chk(cnt_o == 0, "R6 count zero at halt", cnt_o, 0);
    chk(rep0_o == 0, "R6 repeat zero at halt", rep0_o, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; start = 1'b0; stop = 1'b0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!running_o, "R10 reset stopped", running_o, 0);
    chk(cnt_o == 0, "R1 reset count", cnt_o, 0);
    chk(flags_o == 0 && !irq_o, "R9 reset flags", flags_o, 0);

    // nonzero preload, buffered handover, halt
    wr(3'd5, 1);
    wr(3'd0, 4); wr(3'd1, 2); wr(3'd3, 3); wr(3'd2, 3); wr(3'd4, 3);
    @(negedge clk);
    chk(cnt_o == 4, "R11 count write", cnt_o, 4);
    expect_run(4, 2, 3, 3, 3);
    pulse_start();
    wait_halt();
    chk(flags_o == 2'b11, "R5/R3 flags set", flags_o, 3);
    chk(irq_o == 1'b1, "R9 irq with uf enabled", irq_o, 1);

    // flag clearing and mask
    wr(3'd6, 1);
    @(negedge clk);
    chk(flags_o == 2'b10, "R8 w1c clears bit0 only", flags_o, 2);
    chk(irq_o == 1'b0, "R9 irq masked", irq_o, 0);
    wr(3'd5, 2);
    @(negedge clk);
    chk(irq_o == 1'b1, "R9 irq via done enable", irq_o, 1);
    wr(3'd5, 0);
    @(negedge clk);
    chk(irq_o == 1'b0, "R9 all masked", irq_o, 0);
    wr(3'd6, 2);
    @(negedge clk);
    chk(flags_o == 2'b00, "R8 clear bit1", flags_o, 0);

    // buffer already used: no second handover
    wr(3'd0, 2); wr(3'd1, 1); wr(3'd3, 2);
    expect_run(2, 1, 2, 0, 0);
    pulse_start();
    wait_halt();

    // rewriting buffered repeat clears used mark; gated tick
    wr(3'd2, 0); wr(3'd4, 1); wr(3'd0, 0); wr(3'd1, 5); wr(3'd3, 1);
    tick_toggle = 1;
    expect_run(0, 5, 1, 0, 1);
    pulse_start();
    wait_halt();
    tick_toggle = 0;

    // stop freezes, start reloads nothing
    wr(3'd0, 10); wr(3'd1, 3); wr(3'd3, 2);
    pulse_start();
    @(posedge clk); @(posedge clk); #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    @(negedge clk);
    chk(cnt_o == 7, "R10 count frozen at stop", cnt_o, 7);
    chk(rep0_o == 2, "R10 repeat frozen at stop", rep0_o, 2);
    repeat (5) @(negedge clk);
    chk(cnt_o == 7 && !running_o, "R1/R10 stopped count stable", cnt_o, 7);
    @(posedge clk); #1 start = 1'b1; stop = 1'b1;
    @(posedge clk); #1 start = 1'b0; stop = 1'b0;
    @(negedge clk);
    chk(!running_o, "R10 stop wins over start", running_o, 0);
    expect_run(7, 3, 2, 0, 0);
    pulse_start();
    wait_halt();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule